// File: doc/BRIEF.md
# Double-Buffered Compare Timer

This block is an up-counting timer whose compare value can be written straight through or held in a staging buffer. A single write address reaches both the staging buffer and the active compare register. An enable bit decides whether a write lands in both registers or only in the buffer. In the second case the buffer is copied into the compare register only at a point where the timer output waveform can take the change without a glitch: the end of a PWM period, or the start of a new PPG cycle. A control register selects one of three modes (interval, PWM, PPG), the PWM period width, the buffer enable and the run state. A separate period register sets the PPG cycle length.

The counter advances on each clock in which the `tick` input and the run bit are both high. The block has three registered outputs. `match_o` pulses when the counter reaches the compare value. `ovf_o` pulses when the counter wraps from its top value. `tmr_o` is a waveform whose shape depends on the mode. A compare value of zero has a special meaning: the match is raised at counter wrap, not when the counter reads zero. The registers are write-only, and the block has no read path.

Top module: `tmr_cmp_dbuf`

## Requirements
- R1: After reset the counter, the compare, buffer and control registers are zero, the buffer enable is off, and `match_o`, `ovf_o` and `tmr_o` are low.
- R2: In interval mode, with a nonzero compare value C, a step taken while the counter equals C clears the counter to zero. `match_o` is high for exactly one clock after that edge, and `tmr_o` toggles on that edge.
- R3: With a compare value of zero, the match is raised on the step where the counter wraps from its top value. `match_o` and `ovf_o` are therefore high together.
- R4: With the buffer enable off, a write to address 0 loads both the buffer and the compare register. The new value is the active compare value from the next clock.
- R5: With the buffer enable on, in PWM or PPG mode, a write to address 0 loads only the buffer. The compare register keeps its previous value until the next transfer event.
- R6: In interval mode (and in the reserved mode 3), writes to address 0 go directly to the compare register whatever the buffer enable is set to.
- R7: In PWM mode the period is 2^n steps, with n = CNT_W-2, CNT_W-1 or CNT_W for width field values 0, 1 and 2 or 3. `ovf_o` pulses on the wrap. `tmr_o` is set on the wrap and cleared on the match, and the clear wins when both fall on the same step. With the buffer enable on, the buffer is copied into the compare register on the wrap.
- R8: In PPG mode, a step taken while the counter equals the period register (address 1) clears the counter, toggles `tmr_o` and, with the buffer enable on, copies the buffer into the compare register. A compare match also toggles `tmr_o`.
- R9: The counter, `match_o` and `ovf_o` change only on a clock where `tick` is high and the run bit is set.
- R10: The control register is at address 2. Its fields are: bit 0 buffer enable; bits 2:1 mode, where 0 is interval, 1 is PWM, 2 is PPG and 3 acts as interval; bits 4:3 PWM width; bit 5 run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 compare/buffer, 1 period, 2 control |
| wr_data | input | CNT_W | Write data |
| tick | input | 1 | Count enable from an external prescaler |
| match_o | output | 1 | One-clock compare match pulse |
| ovf_o | output | 1 | One-clock counter wrap pulse |
| tmr_o | output | 1 | Mode-dependent timer waveform |

## Verification
Every output is a register driven by the counter state seen at a stepping edge. The result of a step taken at edge k is therefore visible after edge k, and the bench samples it at the falling edge that follows. A write becomes the active compare value one edge after its strobe. With the buffer enabled, the write has no effect until the next wrap or cycle start, so the first match of a phase shows which value was active. The bench counts steps inside each phase and checks the index of the first match, the last match and the number of wraps against values worked out by hand. A behavioural model is also compared with all three outputs at every falling edge.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

   typedef enum logic [1:0] {
      MODE_INTV = 2'b00,
      MODE_PWM  = 2'b01,
      MODE_PPG  = 2'b10,
      MODE_RSVD = 2'b11
   } tmr_mode_e;

   // run | pwm width | mode | buffer enable
   typedef struct packed {
      logic       run;
      logic [1:0] pwm_sel;
      tmr_mode_e  mode;
      logic       dbuf_en;
   } tmr_ctrl_t;

   localparam int CTRL_W = 6;

   localparam logic [1:0] ADDR_CMP  = 2'd0;
   localparam logic [1:0] ADDR_PRD  = 2'd1;
   localparam logic [1:0] ADDR_CTRL = 2'd2;

   function automatic tmr_mode_e eff_mode(input tmr_mode_e m);
      return (m == MODE_RSVD) ? MODE_INTV : m;
   endfunction

endpackage

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs
   import tmr_cmp_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit HAS_PPG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             xfer,
   output tmr_ctrl_t        ctrl_q,
   output logic [CNT_W-1:0] cmp_q,
   output logic [CNT_W-1:0] buf_q,
   output logic [CNT_W-1:0] prd_q
);

   logic wr_cmp;
   logic wr_ctrl;
   logic buffered;

   assign wr_cmp   = wr_en && (wr_addr == ADDR_CMP);
   assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
   // staging only takes effect where a transfer event exists
   assign buffered = ctrl_q.dbuf_en && (eff_mode(ctrl_q.mode) != MODE_INTV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else if (wr_cmp) begin
         buf_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (wr_cmp && !buffered) begin
         cmp_q <= wr_data;
      end else if (xfer) begin
         cmp_q <= buf_q;
      end
   end

   generate
      if (HAS_PPG) begin : g_prd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prd_q <= '1;
            end else if (wr_en && (wr_addr == ADDR_PRD)) begin
               prd_q <= wr_data;
            end
         end
      end else begin : g_no_prd
         assign prd_q = '1;
      end
   endgenerate

endmodule

// File: rtl/tmr_cmp_cnt.sv
module tmr_cmp_cnt
   import tmr_cmp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tmr_ctrl_t        ctrl,
   input  logic [CNT_W-1:0] cmp,
   input  logic [CNT_W-1:0] prd,
   output logic [CNT_W-1:0] cnt_q,
   output tmr_mode_e        mode,
   output logic             ev_match,
   output logic             ev_ovf,
   output logic             ev_end,
   output logic             xfer
);

   localparam int W_MIN = CNT_W - 2;

   logic             step;
   logic [CNT_W-1:0] top_val;
   logic             at_top;
   logic             at_end;
   logic             hit;
   logic             clr;

   assign mode = eff_mode(ctrl.mode);
   assign step = tick && ctrl.run;

   always_comb begin
      top_val = '1;
      if (mode == MODE_PWM) begin
         case (ctrl.pwm_sel)
            2'b00:   top_val = {2'b00, {W_MIN{1'b1}}};
            2'b01:   top_val = {1'b0, {(CNT_W-1){1'b1}}};
            default: top_val = '1;
         endcase
      end
   end

   assign at_top = (cnt_q == top_val);
   assign at_end = (mode == MODE_PPG) && (cnt_q == prd);
   // zero compare means "match on wrap"
   assign hit    = (cmp == '0) ? at_top : (cnt_q == cmp);

   assign ev_match = step && hit;
   assign ev_ovf   = step && at_top;
   assign ev_end   = step && at_end;

   assign xfer = ctrl.dbuf_en &&
                 (((mode == MODE_PWM) && ev_ovf) || ((mode == MODE_PPG) && ev_end));

   assign clr = at_top || at_end || ((mode == MODE_INTV) && hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= clr ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out
   import tmr_cmp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  tmr_mode_e mode,
   input  logic      ev_match,
   input  logic      ev_ovf,
   input  logic      ev_end,
   output logic      match_o,
   output logic      ovf_o,
   output logic      tmr_o
);

   logic tmr_d;

   always_comb begin
      tmr_d = tmr_o;
      unique case (mode)
         MODE_PWM: begin
            if (ev_match)    tmr_d = 1'b0;
            else if (ev_ovf) tmr_d = 1'b1;
         end
         MODE_PPG: tmr_d = tmr_o ^ (ev_match ^ ev_end);
         default:  tmr_d = tmr_o ^ ev_match;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_o <= 1'b0;
         ovf_o   <= 1'b0;
         tmr_o   <= 1'b0;
      end else begin
         match_o <= ev_match;
         ovf_o   <= ev_ovf;
         tmr_o   <= tmr_d;
      end
   end

endmodule

// File: rtl/tmr_cmp_dbuf.sv
module tmr_cmp_dbuf
   import tmr_cmp_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit HAS_PPG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   output logic             match_o,
   output logic             ovf_o,
   output logic             tmr_o
);

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("tmr_cmp_dbuf: CNT_W must hold the control fields");
      end
      if (CNT_W > 16) begin : g_bad_width_hi
         $error("tmr_cmp_dbuf: CNT_W above 16 is not supported");
      end
   endgenerate

   tmr_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] buf_q;
   logic [CNT_W-1:0] prd_q;
   logic [CNT_W-1:0] cnt_q;
   tmr_mode_e        mode;
   logic             ev_match;
   logic             ev_ovf;
   logic             ev_end;
   logic             xfer;

   tmr_cmp_regs #(.CNT_W(CNT_W), .HAS_PPG(HAS_PPG)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .xfer    (xfer),
      .ctrl_q  (ctrl_q),
      .cmp_q   (cmp_q),
      .buf_q   (buf_q),
      .prd_q   (prd_q)
   );

   tmr_cmp_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ctrl     (ctrl_q),
      .cmp      (cmp_q),
      .prd      (prd_q),
      .cnt_q    (cnt_q),
      .mode     (mode),
      .ev_match (ev_match),
      .ev_ovf   (ev_ovf),
      .ev_end   (ev_end),
      .xfer     (xfer)
   );

   tmr_cmp_out u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .ev_match (ev_match),
      .ev_ovf   (ev_ovf),
      .ev_end   (ev_end),
      .match_o  (match_o),
      .ovf_o    (ovf_o),
      .tmr_o    (tmr_o)
   );

endmodule

// File: rtl/tmr_cmp_chk.sv
module tmr_cmp_chk
   import tmr_cmp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic             tick,
   input logic             match_o,
   input logic             ovf_o,
   input logic             tmr_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cmp_q,
   input logic [CNT_W-1:0] buf_q,
   input tmr_ctrl_t        ctrl_q,
   input logic             xfer
);

   // R9
   step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o || ovf_o) |-> ($past(tick) && $past(ctrl_q.run)));

   // R4
   direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_CMP && !ctrl_q.dbuf_en) |=> (cmp_q == $past(wr_data)));

   // R5
   buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_CMP && ctrl_q.dbuf_en && !xfer &&
       (ctrl_q.mode == MODE_PWM || ctrl_q.mode == MODE_PPG))
      |=> (cmp_q == $past(cmp_q) && buf_q == $past(wr_data)));

   // R2
   intv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && $past(ctrl_q.mode) == MODE_INTV) |-> (cnt_q == '0));

   // R3
   zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && $past(cmp_q) == '0) |-> ovf_o);

   // R7
   pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tmr_o) && $past(ctrl_q.mode) == MODE_PWM) |-> ovf_o);

endmodule

bind tmr_cmp_dbuf tmr_cmp_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .tick    (tick),
   .match_o (match_o),
   .ovf_o   (ovf_o),
   .tmr_o   (tmr_o),
   .cnt_q   (cnt_q),
   .cmp_q   (cmp_q),
   .buf_q   (buf_q),
   .ctrl_q  (ctrl_q),
   .xfer    (xfer)
);

// File: tb/tmr_cmp_dbuf_bench.sv
`timescale 1ns/1ps
module tmr_cmp_dbuf_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       tick = 1'b0;
   logic       match_o, ovf_o, tmr_o;

   always #2.5 clk = ~clk;

   tmr_cmp_dbuf u_tmr_cmp_dbuf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick),
      .match_o(match_o), .ovf_o(ovf_o), .tmr_o(tmr_o)
   );

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_cnt, m_cmp, m_buf, m_prd, m_mode, m_sel;
   bit m_dbuf, m_run, m_match, m_ovf, m_out;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_buf = 0; m_prd = 255; m_mode = 0; m_sel = 0;
         m_dbuf = 0; m_run = 0; m_match = 0; m_ovf = 0; m_out = 0;
      end else begin
         int md, top, ncmp;
         bit st, wrap, fin, hit;
         md   = (m_mode == 3) ? 0 : m_mode;
         top  = (md == 1) ? ((1 << (6 + ((m_sel > 1) ? 2 : m_sel))) - 1) : 255;
         st   = tick && m_run;
         wrap = st && (m_cnt == top);
         fin  = st && (md == 2) && (m_cnt == m_prd);
         hit  = st && ((m_cmp == 0) ? (m_cnt == top) : (m_cnt == m_cmp));
         if (md == 1)      m_out = hit ? 1'b0 : (wrap ? 1'b1 : m_out);
         else if (md == 2) m_out = m_out ^ hit ^ fin;
         else              m_out = m_out ^ hit;
         ncmp = m_cmp;
         if (m_dbuf && ((md == 1 && wrap) || (md == 2 && fin))) ncmp = m_buf;
         if (wr_en && wr_addr == 2'd0) begin
            if (!(m_dbuf && md != 0)) ncmp = int'(wr_data);
            m_buf = int'(wr_data);
         end
         if (st) m_cnt = (wrap || fin || (md == 0 && hit)) ? 0 : (m_cnt + 1) % 256;
         m_cmp = ncmp;
         if (wr_en && wr_addr == 2'd1) m_prd = int'(wr_data);
         if (wr_en && wr_addr == 2'd2) begin
            m_dbuf = wr_data[0]; m_mode = int'(wr_data[2:1]);
            m_sel = int'(wr_data[4:3]); m_run = wr_data[5];
         end
         m_match = hit; m_ovf = wrap;
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, int'(match_o), int'(m_match), "match_o vs model");
         check(cur_req, int'(ovf_o),   int'(m_ovf),   "ovf_o vs model");
         check(cur_req, int'(tmr_o),   int'(m_out),   "tmr_o vs model");
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   int n_match, n_ovf, first_m, last_m;

   task automatic run_ticks(input int n);
      n_match = 0; n_ovf = 0; first_m = -1; last_m = -1;
      tick = 1'b1;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (match_o) begin
            n_match++;
            if (first_m < 0) first_m = i;
            last_m = i;
         end
         if (ovf_o) n_ovf++;
      end
      tick = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", int'(match_o), 0, "match_o in reset");
      check("R1", int'(ovf_o),   0, "ovf_o in reset");
      check("R1", int'(tmr_o),   0, "tmr_o in reset");
      rst_n = 1'b1;

      // R9: no run bit, no stepping
      cur_req = "R9";
      wr(2'd0, 8'd4);
      run_ticks(20);
      check("R9", n_match, 0, "matches with run bit clear");

      // R2: interval, compare 4 -> period 5
      cur_req = "R2";
      wr(2'd2, 8'h20);
      run_ticks(50);
      check("R2", n_match, 10, "interval matches");
      check("R2", first_m, 5, "interval first match step");

      // R3: zero compare matches on wrap
      cur_req = "R3";
      wr(2'd0, 8'd0);
      run_ticks(512);
      check("R3", n_match, 2, "zero-compare matches");
      check("R3", n_ovf, 2, "zero-compare wraps");
      check("R3", first_m, 256, "zero-compare first match step");

      // R6: interval ignores buffer enable
      cur_req = "R6";
      wr(2'd2, 8'h21);
      wr(2'd0, 8'd9);
      run_ticks(30);
      check("R6", n_match, 3, "interval with enable set");
      check("R6", first_m, 10, "direct write active at once");

      // R5/R7: PWM 6-bit, buffered write waits for wrap
      cur_req = "R5";
      wr(2'd2, 8'h23);
      wr(2'd0, 8'd20);
      run_ticks(128);
      check("R5", first_m, 10, "old compare kept until wrap");
      check("R7", last_m, 85, "buffer copied at PWM wrap");
      check("R7", n_ovf, 2, "6-bit PWM wraps");

      // R8: PPG, period 9, buffered compare 3
      cur_req = "R8";
      wr(2'd2, 8'h25);
      wr(2'd1, 8'd9);
      wr(2'd0, 8'd3);
      run_ticks(40);
      check("R8", n_match, 3, "PPG matches");
      check("R8", first_m, 14, "buffer copied at cycle start");

      // R4: buffer off, 8-bit PWM, direct write
      cur_req = "R4";
      wr(2'd2, 8'h32);
      wr(2'd0, 8'd100);
      run_ticks(256);
      check("R4", first_m, 101, "unbuffered write active at once");
      check("R4", n_ovf, 1, "8-bit PWM wraps");

      // R7: 7-bit PWM width
      cur_req = "R7";
      wr(2'd2, 8'h2A);
      run_ticks(256);
      check("R7", n_ovf, 2, "7-bit PWM wraps");
      check("R7", n_match, 2, "7-bit PWM matches");

      // R10: random writes, modes and ticks against the model
      cur_req = "R10";
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         wr_en   = ($urandom % 8) == 0;
         wr_addr = 2'($urandom);
         wr_data = 8'($urandom);
         if (wr_addr == 2'd2) wr_data[5] = 1'b1;
         tick    = ($urandom % 4) != 0;
      end
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule